// File: doc/BRIEF.md
# Data Enable Window Generator

This block frames the visible picture inside each output frame on the pixel clock. It watches the horizontal and vertical output sync pulses and counts pixel clocks from the trailing (falling) edge of the horizontal sync. It counts lines as horizontal trailing edges since the last vertical trailing edge. From these counts it drives a registered data-enable that is high only inside a programmable rectangle. Two single-cycle markers flag the first enabled pixel of each active line and the first enabled pixel of the frame's first active line.

The rectangle has four programmed values: a pixel offset (10 bits), a pixel count (12 bits), a line offset (10 bits) and a line count (12 bits). They are copied into shadow registers only on a vertical trailing edge. A frame therefore always uses one consistent setting. After reset the shadow holds an SXGA-style window: pixel offset 246, 1280 pixels, line offset 38 and 1024 lines. After reset both counters start as if both syncs had just ended, so the reset window is visible before any vertical edge arrives.

Top module: `de_window_gen`

## Requirements
- R1: While reset is low and on the first clock after it, `de_out`, `first_pix_out` and `first_line_out` are 0. The shadow holds pixel offset 246, pixel count 1280, line offset 38 and line count 1024. The pixel position and line index are both 0 at the last reset clock.
- R2: The pixel position is 0 at the clock edge where `hsync_in` is sampled low after being sampled high. It then rises by one per clock. `de_out` can be high only for positions p with offset <= p < offset + count, and the output for a position appears right after the edge that reaches it.
- R3: The line index rises by one at each horizontal trailing edge and returns to 0 at a vertical trailing edge. Only lines with line offset <= index < line offset + line count are active.
- R4: `de_out` is high exactly when the horizontal window and the vertical window are both active.
- R5: A change on the four programming inputs has no effect until the next vertical trailing edge. At that edge the new values are already used for the pixel it starts.
- R6: A pixel count of 0 or a line count of 0 keeps `de_out` and both markers at 0.
- R7: A horizontal trailing edge restarts the pixel position at 0 and a vertical trailing edge restarts the line index at 0. Any part of a window that extends past the next edge is cut off there.
- R8: `first_pix_out` is high for one clock, together with `de_out`, at pixel position equal to the pixel offset on each active line.
- R9: `first_line_out` is high only together with `first_pix_out`, on the active line whose index equals the line offset.
- R10: When vertical and horizontal trailing edges fall in the same clock, the vertical one wins: the line index becomes 0, not incremented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hsync_in | input | 1 | Horizontal output sync, active high |
| vsync_in | input | 1 | Vertical output sync, active high |
| h_start_in | input | 10 | Pixel clocks from horizontal trailing edge to first visible pixel |
| h_len_in | input | 12 | Visible pixels per line |
| v_start_in | input | 10 | Lines from vertical trailing edge to first visible line |
| v_len_in | input | 12 | Visible lines per frame |
| de_out | output | 1 | Registered data enable |
| first_pix_out | output | 1 | Pulse on first visible pixel of each active line |
| first_line_out | output | 1 | Pulse on first visible pixel of the first active line |

## Verification
Two actions can fall in the same clock: the vertical trailing edge loads the shadow and clears the line index, while a horizontal trailing edge restarts the pixel position and would normally advance the line index. The bench provokes this by dropping `vsync_in` in exactly the cycle where `hsync_in` drops. It then expects the window with offset 0 and one line to open at position 0 of line index 0, with both markers set. When the vertical drop comes two cycles earlier instead, the same settings must give no enable at all.

// File: rtl/dew_pkg.sv
package dew_pkg;

    localparam int HST_W = 10;
    localparam int HWD_W = 12;
    localparam int VST_W = 10;
    localparam int VHT_W = 12;

    typedef struct packed {
        logic [HST_W-1:0] h_start;
        logic [HWD_W-1:0] h_len;
        logic [VST_W-1:0] v_start;
        logic [VHT_W-1:0] v_len;
    } win_cfg_t;

    typedef struct packed {
        logic de;
        logic pix_mark;
        logic line_mark;
    } win_out_t;

endpackage

// File: rtl/dew_trail_detect.sv
module dew_trail_detect #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] sync_in,
    output logic [N-1:0] trail
);

    typedef struct packed {
        logic [N-1:0] prev;
    } trail_st_t;

    trail_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.prev = sync_in;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // one falling-edge flag per sync channel
    for (genvar g = 0; g < N; g++) begin : g_trail
        assign trail[g] = st_q.prev[g] & ~sync_in[g];
    end

endmodule

// File: rtl/dew_axis.sv
module dew_axis #(
    parameter int START_W = 10,
    parameter int LEN_W   = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               restart,
    input  logic               step,
    input  logic [START_W-1:0] start,
    input  logic [LEN_W-1:0]   len,
    output logic               active_d,
    output logic               at_start_d
);

    localparam int POS_W = ((START_W > LEN_W) ? START_W : LEN_W) + 1;
    localparam logic [POS_W-1:0] POS_MAX = '1;

    typedef struct packed {
        logic [POS_W-1:0] pos;
    } axis_st_t;

    axis_st_t st_d, st_q;
    logic [POS_W-1:0] start_x;
    logic [POS_W-1:0] end_x;

    always_comb begin
        st_d = st_q;
        if (restart) begin
            st_d.pos = '0;
        end else if (step && (st_q.pos != POS_MAX)) begin
            st_d.pos = st_q.pos + 1'b1;
        end

        start_x    = POS_W'(start);
        end_x      = start_x + POS_W'(len);
        active_d   = (len != '0) && (st_d.pos >= start_x) && (st_d.pos < end_x);
        at_start_d = (st_d.pos == start_x);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/dew_shadow.sv
module dew_shadow
    import dew_pkg::*;
#(
    parameter win_cfg_t RST_CFG = '0
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     load,
    input  win_cfg_t cfg_in,
    output win_cfg_t cfg_d,
    output win_cfg_t cfg_q
);

    always_comb begin
        cfg_d = cfg_q;
        if (load) begin
            cfg_d = cfg_in;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= RST_CFG;
        end else begin
            cfg_q <= cfg_d;
        end
    end

endmodule

// File: rtl/de_window_gen.sv
module de_window_gen
    import dew_pkg::*;
#(
    parameter int HSTART_RST  = 246,
    parameter int HWIDTH_RST  = 1280,
    parameter int VSTART_RST  = 38,
    parameter int VHEIGHT_RST = 1024
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hsync_in,
    input  logic             vsync_in,
    input  logic [HST_W-1:0] h_start_in,
    input  logic [HWD_W-1:0] h_len_in,
    input  logic [VST_W-1:0] v_start_in,
    input  logic [VHT_W-1:0] v_len_in,
    output logic             de_out,
    output logic             first_pix_out,
    output logic             first_line_out
);

    localparam win_cfg_t RST_CFG = '{
        h_start: HST_W'(HSTART_RST),
        h_len:   HWD_W'(HWIDTH_RST),
        v_start: VST_W'(VSTART_RST),
        v_len:   VHT_W'(VHEIGHT_RST)
    };

    logic [1:0] trail;
    logic       h_trail;
    logic       v_trail;
    win_cfg_t   cfg_in;
    win_cfg_t   cfg_d;
    win_cfg_t   cfg_q;
    logic       h_act, h_first;
    logic       v_act, v_first;
    win_out_t   out_d, out_q;

    dew_trail_detect #(.N(2)) u_trail (
        .clk     (clk),
        .rst_n   (rst_n),
        .sync_in ({vsync_in, hsync_in}),
        .trail   (trail)
    );

    assign h_trail = trail[0];
    assign v_trail = trail[1];

    assign cfg_in = '{
        h_start: h_start_in,
        h_len:   h_len_in,
        v_start: v_start_in,
        v_len:   v_len_in
    };

    // settings swap only when a new frame begins
    dew_shadow #(.RST_CFG(RST_CFG)) u_shadow (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (v_trail),
        .cfg_in (cfg_in),
        .cfg_d  (cfg_d),
        .cfg_q  (cfg_q)
    );

    // pixel position: restarts on horizontal trailing edge, steps every clock
    dew_axis #(.START_W(HST_W), .LEN_W(HWD_W)) u_h_axis (
        .clk        (clk),
        .rst_n      (rst_n),
        .restart    (h_trail),
        .step       (1'b1),
        .start      (cfg_d.h_start),
        .len        (cfg_d.h_len),
        .active_d   (h_act),
        .at_start_d (h_first)
    );

    // line index: restarts on vertical trailing edge (wins), steps per line
    dew_axis #(.START_W(VST_W), .LEN_W(VHT_W)) u_v_axis (
        .clk        (clk),
        .rst_n      (rst_n),
        .restart    (v_trail),
        .step       (h_trail),
        .start      (cfg_d.v_start),
        .len        (cfg_d.v_len),
        .active_d   (v_act),
        .at_start_d (v_first)
    );

    always_comb begin
        out_d           = out_q;
        out_d.de        = h_act && v_act;
        out_d.pix_mark  = out_d.de && h_first;
        out_d.line_mark = out_d.pix_mark && v_first;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign de_out         = out_q.de;
    assign first_pix_out  = out_q.pix_mark;
    assign first_line_out = out_q.line_mark;

endmodule

// File: rtl/dew_check.sv
module dew_check
    import dew_pkg::*;
(
    input logic     clk,
    input logic     rst_n,
    input logic     de,
    input logic     fp,
    input logic     fl,
    input logic     v_trail,
    input win_cfg_t cfg_q
);

    assert_pix_mark_in_de_R8: assert property (@(posedge clk) disable iff (!rst_n)
        fp |-> de);

    assert_pix_mark_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        fp |=> !fp);

    assert_line_mark_in_pix_R9: assert property (@(posedge clk) disable iff (!rst_n)
        fl |-> fp);

    assert_zero_size_dark_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((cfg_q.h_len == '0) || (cfg_q.v_len == '0)) |-> (!de && !fp && !fl));

    assert_shadow_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !v_trail |=> $stable(cfg_q));

endmodule

bind de_window_gen dew_check u_dew_check (
    .clk     (clk),
    .rst_n   (rst_n),
    .de      (de_out),
    .fp      (first_pix_out),
    .fl      (first_line_out),
    .v_trail (v_trail),
    .cfg_q   (cfg_q)
);

// File: tb/de_window_gen_bench.sv
module de_window_gen_bench;
    import dew_pkg::*;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic hs = 1'b0;
    logic vs = 1'b0;
    logic [HST_W-1:0] hst = 10'd246;
    logic [HWD_W-1:0] hwd = 12'd1280;
    logic [VST_W-1:0] vst = 10'd38;
    logic [VHT_W-1:0] vht = 12'd1024;
    logic de, fp, fl;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    de_window_gen u_de_window_gen (
        .clk            (clk),
        .rst_n          (rst_n),
        .hsync_in       (hs),
        .vsync_in       (vs),
        .h_start_in     (hst),
        .h_len_in       (hwd),
        .v_start_in     (vst),
        .v_len_in       (vht),
        .de_out         (de),
        .first_pix_out  (fp),
        .first_line_out (fl)
    );

    // requirement model: positions per R2/R3/R7/R10, shadow per R5
    bit m_ph, m_pv;
    int m_hpos, m_line;
    int m_hs, m_hw, m_vs, m_vh;
    bit e_de, e_fp, e_fl;

    always @(posedge clk) begin
        bit hf, vf, ha, va;
        if (!rst_n) begin
            m_ph = 0; m_pv = 0; m_hpos = 0; m_line = 0;
            m_hs = 246; m_hw = 1280; m_vs = 38; m_vh = 1024;
            e_de = 0; e_fp = 0; e_fl = 0;
        end else begin
            hf = m_ph && !hs;
            vf = m_pv && !vs;
            m_ph = hs;
            m_pv = vs;
            if (vf) begin
                m_hs = int'(hst); m_hw = int'(hwd); m_vs = int'(vst); m_vh = int'(vht);
                m_line = 0;
            end else if (hf && m_line < 8191) begin
                m_line = m_line + 1;
            end
            if (hf) m_hpos = 0;
            else if (m_hpos < 8191) m_hpos = m_hpos + 1;
            ha = (m_hw != 0) && (m_hpos >= m_hs) && (m_hpos < m_hs + m_hw);
            va = (m_vh != 0) && (m_line >= m_vs) && (m_line < m_vs + m_vh);
            e_de = ha && va;
            e_fp = e_de && (m_hpos == m_hs);
            e_fl = e_fp && (m_line == m_vs);
        end
    end

    int mism = 0;
    int c_de = 0, c_fp = 0, c_fl = 0;

    always @(negedge clk) begin
        if ((de !== e_de) || (fp !== e_fp) || (fl !== e_fl)) mism++;
        c_de += int'(de === 1'b1);
        c_fp += int'(fp === 1'b1);
        c_fl += int'(fl === 1'b1);
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic clear_counts();
        mism = 0; c_de = 0; c_fp = 0; c_fl = 0;
    endtask

    task automatic run_lines(input int n, input int period, input int hs_len,
                             input int vs_from, input int vs_to, input int vs_off);
        for (int l = 0; l < n; l++) begin
            for (int c = 0; c < period; c++) begin
                @(negedge clk);
                hs = (c < hs_len);
                if (c == vs_off) vs = (l >= vs_from) && (l < vs_to);
            end
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (5) @(negedge clk);
        chk("R1 de in reset", int'(de), 0);
        chk("R1 first_pix in reset", int'(fp), 0);
        chk("R1 first_line in reset", int'(fl), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 outputs first clock after reset", int'({de, fp, fl}), 0);
    endtask

    // reset window: lines 38..40 of 40 lines, pixels 246..1525
    task automatic t_default();
        clear_counts();
        run_lines(40, 1600, 8, 0, 0, 0);
        chk("R1 R2 default window enabled pixels", c_de, 3 * 1280);
        chk("R8 default first-pixel pulses", c_fp, 3);
        chk("R9 default first-line pulses", c_fl, 1);
        chk("R3 R4 default model compare", mism, 0);
    endtask

    task automatic t_shadow();
        hst = 10'd4; hwd = 12'd6; vst = 10'd1; vht = 12'd2;
        clear_counts();
        run_lines(2, 1600, 8, 0, 0, 0);
        chk("R5 new inputs ignored before vertical edge", c_de, 2 * 1280);
        chk("R5 pixel pulses under old settings", c_fp, 2);
        chk("R5 model compare", mism, 0);
    endtask

    task automatic t_frame(input string tag, input int a, input int b, input int c,
                           input int d, input int vs_off,
                           input int x_de, input int x_fp, input int x_fl);
        hst = HST_W'(a); hwd = HWD_W'(b); vst = VST_W'(c); vht = VHT_W'(d);
        clear_counts();
        run_lines(6, 20, 2, 0, 1, vs_off);
        chk({tag, " enabled pixels"}, c_de, x_de);
        chk({tag, " first-pixel pulses"}, c_fp, x_fp);
        chk({tag, " first-line pulses"}, c_fl, x_fl);
        chk({tag, " model compare"}, mism, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_default();
        t_shadow();
        t_frame("R2 R3 small window", 4, 6, 1, 2, 0, 12, 2, 1);
        t_frame("R7 window cut by next hsync", 15, 10, 1, 2, 0, 10, 2, 1);
        t_frame("R3 line 0 before first hsync", 0, 3, 0, 1, 0, 0, 0, 0);
        t_frame("R10 coincident edges", 0, 3, 0, 1, 2, 3, 1, 1);
        t_frame("R6 zero width", 4, 0, 1, 2, 0, 0, 0, 0);
        t_frame("R6 zero height", 4, 6, 1, 0, 0, 0, 0, 0);
        t_frame("R4 R8 full-line window", 0, 20, 1, 1, 0, 20, 1, 1);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule